// File: doc/BRIEF.md
# I2C Reserved Device-ID Responder

This block sits beside an I2C memory slave and answers the two-phase identification command only. It samples SCL and SDA with the system clock and finds start and stop conditions the same way the memory slave does. Like the memory slave, it pulls SDA low through an open-drain enable and never drives it high.

The command has an opening phase and a fetch phase. In the opening phase the master sends the reserved opening byte, followed by a device word that names this device. In the fetch phase, after a repeated start, the master sends the reserved fetch byte. The block then streams a fixed identification value one byte at a time. The master acknowledges each byte it wants more of. A NACK ends the stream, and a stop at any point throws away a half-finished command. The identification value, the reserved codes and the device type nibble are parameters.

Top module: `i2c_id_responder`

## Requirements
- R1: After reset the SDA pull-down enable is deasserted and no command is in progress.
- R2: A byte of 0xF8 as the first byte after a start is acknowledged: SDA is pulled low for the ninth clock.
- R3: After an acknowledged 0xF8, the next byte is acknowledged only if its bits [7:4] equal the type nibble 4'b1010 and its bits [3:1] equal the three strap inputs. Bit 0 (read/write) can be 0 or 1.
- R4: After the device word of R3 has been acknowledged, a repeated start followed by 0xF9 is acknowledged.
- R5: After the acknowledged 0xF9 the block sends ID_VALUE[23:16], then [15:8], then [7:0], each MSB first. With the default value 24'h00A510 these are 0x00, 0xA5 and 0x10.
- R6: If the master acknowledges the last ID byte, the stream starts again at the first byte. A NACK releases SDA and ends the transfer.
- R7: A device word that does not match is not acknowledged and cancels the command, so a later 0xF9 is not acknowledged.
- R8: A 0xF9 that does not follow a qualified opening phase is not acknowledged.
- R9: A stop clears any partly qualified command, and a later 0xF9 is not acknowledged.
- R10: SDA is pulled low only in acknowledge slots the block owns and in the zero bits of ID bytes. Any other traffic is left alone, so bytes read from the bus with no stream active come back as 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND bus value) |
| strap_i | input | 3 | Device address straps compared with device-word bits [3:1] |
| sda_oe | output | 1 | High to pull SDA low; low releases the line |

## Verification
Some properties are checked by assertions on every cycle. SDA may only change drive right after an SCL falling edge or a bus condition. The line is released whenever the block is idle or waiting for the master's acknowledge. A start or stop releases it at once. The ID index stays within range and wraps to zero. A stop empties the command phase, and the armed phase can only be entered from the opened phase. Some behaviour only the bench scenarios can show, because it depends on byte values across a whole transaction. These are the acknowledge decisions for matching and mismatched device words, the exact ID byte order, the wrap after the last byte, and the 0xFF seen when a foreign transfer is read back.

// File: rtl/i2c_id_pkg.sv
package i2c_id_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK_OUT,
    ST_TX,
    ST_ACK_IN
  } bus_state_t;

  typedef enum logic [1:0] {
    PH_NONE,
    PH_OPENED,
    PH_ARMED
  } id_phase_t;

  // true when a device word names this device; bit 0 (R/W) is not looked at
  function automatic logic dev_word_ok(input logic [7:0] b,
                                       input logic [3:0] type_code,
                                       input logic [2:0] strap);
    return (b[7:4] == type_code) && (b[3:1] == strap);
  endfunction

  // index step with wrap at count n
  function automatic int unsigned wrap_inc(input int unsigned v,
                                           input int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/i2c_line_sense.sv
module i2c_line_sense #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);

  logic [STAGES-1:0] scl_sh, sda_sh;
  logic              scl_q, sda_q;
  logic              scl_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= {STAGES{1'b1}};
      sda_sh <= {STAGES{1'b1}};
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_lvl   = scl_sh[STAGES-1];
  assign sda_lvl   = sda_sh[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  assign bus_start = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign bus_stop  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/i2c_id_bitfsm.sv
module i2c_id_bitfsm
  import i2c_id_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       bus_start,
  input  logic       bus_stop,
  input  logic       ack_rx,
  input  logic       tx_go,
  input  logic [7:0] tx_first_byte,
  input  logic [7:0] tx_next_byte,
  output logic [7:0] rx_byte,
  output logic       rx_first,
  output logic       rx_commit,
  output logic       tx_begin,
  output logic       master_ack_ev,
  output logic       sda_oe
);

  bus_state_t state;
  logic [3:0] bit_cnt;
  logic [7:0] shreg;
  logic       first_q;
  logic       go_tx_q;
  logic       mack_q;

  assign rx_byte       = shreg;
  assign rx_first      = first_q;
  assign rx_commit     = (state == ST_RX) && scl_fall && (bit_cnt == 4'd8);
  assign tx_begin      = (state == ST_ACK_OUT) && scl_fall && go_tx_q;
  assign master_ack_ev = (state == ST_ACK_IN) && scl_fall && mack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      first_q <= 1'b0;
      go_tx_q <= 1'b0;
      mack_q  <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (bus_start) begin
      state   <= ST_RX;
      bit_cnt <= '0;
      first_q <= 1'b1;
      sda_oe  <= 1'b0;
    end else if (bus_stop) begin
      state   <= ST_IDLE;
      first_q <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (scl_rise && bit_cnt < 4'd8) begin
            shreg   <= {shreg[6:0], sda_lvl};
            bit_cnt <= bit_cnt + 4'd1;
          end
          if (rx_commit) begin
            if (ack_rx) begin
              state   <= ST_ACK_OUT;
              go_tx_q <= tx_go;
              sda_oe  <= 1'b1;
            end else begin
              state   <= ST_IDLE;
              sda_oe  <= 1'b0;
            end
          end
        end
        ST_ACK_OUT: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            first_q <= 1'b0;
            if (go_tx_q) begin
              state  <= ST_TX;
              shreg  <= tx_first_byte;
              sda_oe <= ~tx_first_byte[7];
            end else begin
              state  <= ST_RX;
              sda_oe <= 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_rise && bit_cnt < 4'd8) bit_cnt <= bit_cnt + 4'd1;
          if (scl_fall) begin
            if (bit_cnt == 4'd8) begin
              state  <= ST_ACK_IN;
              sda_oe <= 1'b0;
            end else begin
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
            end
          end
        end
        ST_ACK_IN: begin
          if (scl_rise) mack_q <= ~sda_lvl;
          if (scl_fall) begin
            bit_cnt <= '0;
            if (mack_q) begin
              state  <= ST_TX;
              shreg  <= tx_next_byte;
              sda_oe <= ~tx_next_byte[7];
            end else begin
              state  <= ST_IDLE;
              sda_oe <= 1'b0;
            end
          end
        end
        default: sda_oe <= 1'b0;
      endcase
    end
  end

  AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> ($past(scl_fall) || $past(bus_start) || $past(bus_stop))); // R10
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe); // R10
  AST_ACK_IN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACK_IN) |-> !sda_oe); // R6
  AST_EVENT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start || bus_stop) |=> !sda_oe); // R9

endmodule

// File: rtl/i2c_id_gate.sv
module i2c_id_gate
  import i2c_id_pkg::*;
#(
  parameter logic [7:0] OPEN_CODE  = 8'hF8,
  parameter logic [7:0] FETCH_CODE = 8'hF9,
  parameter logic [3:0] TYPE_CODE  = 4'hA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_stop,
  input  logic [2:0] strap,
  input  logic [7:0] rx_byte,
  input  logic       rx_first,
  input  logic       rx_commit,
  output logic       ack_rx,
  output logic       tx_go
);

  id_phase_t phase;
  logic      open_hit, word_hit, fetch_hit;

  assign open_hit  = rx_first && (rx_byte == OPEN_CODE);
  assign fetch_hit = rx_first && (rx_byte == FETCH_CODE) && (phase == PH_ARMED);
  assign word_hit  = !rx_first && (phase == PH_OPENED)
                     && dev_word_ok(rx_byte, TYPE_CODE, strap);
  assign ack_rx    = open_hit || word_hit || fetch_hit;
  assign tx_go     = fetch_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_NONE;
    end else if (bus_stop) begin
      phase <= PH_NONE;
    end else if (rx_commit) begin
      if (open_hit)      phase <= PH_OPENED;
      else if (word_hit) phase <= PH_ARMED;
      else               phase <= PH_NONE;
    end
  end

  AST_ARM_FROM_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ARMED && $past(phase) != PH_ARMED) |-> $past(phase) == PH_OPENED); // R3
  AST_STOP_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> (phase == PH_NONE)); // R9

endmodule

// File: rtl/i2c_id_source.sv
module i2c_id_source
  import i2c_id_pkg::*;
#(
  parameter int                   ID_BYTES = 3,
  parameter logic [ID_BYTES*8-1:0] ID_VALUE = 24'h00A510
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_begin,
  input  logic       master_ack_ev,
  output logic [7:0] tx_first_byte,
  output logic [7:0] tx_next_byte
);

  localparam int IDX_W  = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1;
  localparam int TBL_SZ = 1 << IDX_W;

  logic [7:0]       id_tbl [TBL_SZ];
  logic [IDX_W-1:0] idx, idx_nxt;

  for (genvar g = 0; g < TBL_SZ; g++) begin : g_tbl
    if (g < ID_BYTES) begin : g_used
      assign id_tbl[g] = ID_VALUE[(ID_BYTES-1-g)*8 +: 8];
    end else begin : g_pad
      assign id_tbl[g] = 8'h00;
    end
  end

  assign idx_nxt       = IDX_W'(wrap_inc(int'(idx), ID_BYTES));
  assign tx_first_byte = id_tbl[0];
  assign tx_next_byte  = id_tbl[idx_nxt];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             idx <= '0;
    else if (tx_begin)      idx <= '0;
    else if (master_ack_ev) idx <= idx_nxt;
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx) < ID_BYTES); // R5
  AST_IDX_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (master_ack_ev && int'(idx) == ID_BYTES-1) |=> (idx == '0)); // R6

endmodule

// File: rtl/i2c_id_responder.sv
module i2c_id_responder #(
  parameter int                   ID_BYTES    = 3,
  parameter logic [ID_BYTES*8-1:0] ID_VALUE    = 24'h00A510,
  parameter logic [7:0]           OPEN_CODE   = 8'hF8,
  parameter logic [7:0]           FETCH_CODE  = 8'hF9,
  parameter logic [3:0]           TYPE_CODE   = 4'hA,
  parameter int                   SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_oe
);

  logic       sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
  logic [7:0] rx_byte, tx_first_byte, tx_next_byte;
  logic       rx_first, rx_commit, tx_begin, master_ack_ev;
  logic       ack_rx, tx_go;

  i2c_line_sense #(.STAGES(SYNC_STAGES)) u_sense (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  i2c_id_bitfsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop),
    .ack_rx(ack_rx), .tx_go(tx_go),
    .tx_first_byte(tx_first_byte), .tx_next_byte(tx_next_byte),
    .rx_byte(rx_byte), .rx_first(rx_first), .rx_commit(rx_commit),
    .tx_begin(tx_begin), .master_ack_ev(master_ack_ev), .sda_oe(sda_oe)
  );

  i2c_id_gate #(
    .OPEN_CODE(OPEN_CODE), .FETCH_CODE(FETCH_CODE), .TYPE_CODE(TYPE_CODE)
  ) u_gate (
    .clk(clk), .rst_n(rst_n), .bus_stop(bus_stop), .strap(strap_i),
    .rx_byte(rx_byte), .rx_first(rx_first), .rx_commit(rx_commit),
    .ack_rx(ack_rx), .tx_go(tx_go)
  );

  i2c_id_source #(.ID_BYTES(ID_BYTES), .ID_VALUE(ID_VALUE)) u_src (
    .clk(clk), .rst_n(rst_n), .tx_begin(tx_begin),
    .master_ack_ev(master_ack_ev),
    .tx_first_byte(tx_first_byte), .tx_next_byte(tx_next_byte)
  );

endmodule

// File: tb/test_i2c_id_responder.sv
module test_i2c_id_responder;

  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic [2:0] strap = 3'd5;
  logic       sda_oe;
  logic       sda_line;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;

  int    exp_q[$];
  string tag_q[$];
  int    obs_q[$];

  always #2.5 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;

  i2c_id_responder i_i2c_id_responder (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .strap_i(strap), .sda_oe(sda_oe)
  );

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic chk(input int act, input int expv, input string tag);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; qwait(); m_scl = 1'b1; qwait();
    m_sda = 1'b0; qwait(); m_scl = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; qwait(); m_scl = 1'b1; qwait();
    m_sda = 1'b1; qwait();
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; qwait(); m_scl = 1'b1; qwait(); qwait(); m_scl = 1'b0; qwait();
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; qwait(); m_scl = 1'b1; qwait();
    b = sda_line; qwait(); m_scl = 1'b0; qwait();
  endtask

  // master writes a byte; expected ack level (0 = ack) queued for the monitor
  task automatic wr(input logic [7:0] b, input int exp_ack, input string tag);
    logic a;
    exp_q.push_back(exp_ack); tag_q.push_back(tag);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(a);
    obs_q.push_back(int'(a));
  endtask

  // master reads a byte then answers ack (1) or nack (0)
  task automatic rd(input logic [7:0] expv, input bit give_ack, input string tag);
    logic [7:0] v;
    logic       b;
    exp_q.push_back(int'(expv)); tag_q.push_back(tag);
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~give_ack);
    m_sda = 1'b1;
    obs_q.push_back(int'(v));
  endtask

  // monitor: pops observed results and compares with expected items
  initial begin
    forever begin
      @(negedge clk);
      while (obs_q.size() > 0) begin
        int    o;
        int    e;
        string t;
        o = obs_q.pop_front();
        if (exp_q.size() > 0) begin
          e = exp_q.pop_front(); t = tag_q.pop_front();
        end else begin
          e = -1; t = "scoreboard";
        end
        chk(o, e, t);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(int'(sda_oe), 0, "R1 reset release");
    rst_n = 1'b1;
    qwait();
    chk(int'(sda_oe), 0, "R1 idle after reset");

    // full command, strap 5, R/W=0, wrap once then nack
    bus_start();
    wr(8'hF8, 0, "R2 open byte ack");
    wr(8'hAA, 0, "R3 device word rw0 ack");
    bus_start();
    wr(8'hF9, 0, "R4 fetch ack");
    rd(8'h00, 1'b1, "R5 id byte0");
    rd(8'hA5, 1'b1, "R5 id byte1");
    rd(8'h10, 1'b1, "R5 id byte2");
    rd(8'h00, 1'b0, "R6 wrap to byte0");
    chk(int'(sda_oe), 0, "R6 release after nack");
    bus_stop();

    // R/W=1 in device word
    bus_start();
    wr(8'hF8, 0, "R2 open byte ack");
    wr(8'hAB, 0, "R3 device word rw1 ack");
    bus_start();
    wr(8'hF9, 0, "R4 fetch ack");
    rd(8'h00, 1'b1, "R5 id byte0");
    rd(8'hA5, 1'b0, "R5 id byte1 nack");
    bus_stop();

    // different strap
    strap = 3'd2;
    bus_start();
    wr(8'hF8, 0, "R2 open byte ack");
    wr(8'hA4, 0, "R3 strap 2 word ack");
    bus_start();
    wr(8'hF9, 0, "R4 fetch ack");
    rd(8'h00, 1'b1, "R5 id byte0");
    rd(8'hA5, 1'b1, "R5 id byte1");
    rd(8'h10, 1'b0, "R5 id byte2 nack");
    bus_stop();

    // mismatched strap cancels the command
    bus_start();
    wr(8'hF8, 0, "R2 open byte ack");
    wr(8'hAA, 1, "R7 strap mismatch nack");
    bus_start();
    wr(8'hF9, 1, "R7 fetch after mismatch nack");
    bus_stop();

    // wrong type nibble
    bus_start();
    wr(8'hF8, 0, "R2 open byte ack");
    wr(8'hB4, 1, "R3 wrong type nack");
    bus_stop();

    // fetch with no opening phase
    bus_start();
    wr(8'hF9, 1, "R8 cold fetch nack");
    bus_stop();

    // stop between phases
    bus_start();
    wr(8'hF8, 0, "R2 open byte ack");
    wr(8'hA4, 0, "R3 word ack");
    bus_stop();
    bus_start();
    wr(8'hF9, 1, "R9 fetch after stop nack");
    bus_stop();

    // foreign traffic is not touched
    bus_start();
    wr(8'hA4, 1, "R10 memory address ignored");
    wr(8'h00, 1, "R10 data byte ignored");
    rd(8'hFF, 1'b0, "R10 bus left released");
    bus_stop();
    chk(int'(sda_oe), 0, "R10 released after foreign traffic");

    // command still works afterwards
    bus_start();
    wr(8'hF8, 0, "R2 open byte ack");
    wr(8'hA5, 0, "R3 word rw1 strap2 ack");
    bus_start();
    wr(8'hF9, 0, "R4 fetch ack");
    rd(8'h00, 1'b0, "R5 id byte0 nack");
    bus_stop();

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule